// File: doc/BRIEF.md
# Two-Wire Serial Memory Bus Engine

This block is the bus-facing controller of a serial memory that sits on a two-wire clock/data bus. A fast system clock oversamples the bus clock and data lines. The block recognises bus conditions, decodes a control byte against three strap pins, and collects a 16-bit word address. It acknowledges every accepted byte and serves current-address, sequential and random reads. It drives the data line only through an active-high pull-low enable, so the line is never driven high.

Each received write byte goes to a separate programming sequencer as a one-cycle strobe that carries the byte and its target address. A STOP that closes a write with at least one data byte produces a commit pulse. The sequencer returns a busy flag, and while that flag is high the block refuses new commands so the bus master can poll for completion. Read data comes from the storage array through an address output and a data input. The array is sampled one full bit period after the address settles.

Top module: `eeprom_bus_engine`

## Requirements
- R1: A START is the data line falling while the clock is high, and a STOP is the data line rising while the clock is high. Bytes clocked outside a command that began with a START are never acknowledged, and a STOP always returns the block to idle.
- R2: A control byte is accepted only when bits 7:4 equal 1010 and bits 3:1 equal the strap pins. Bit 0 set to 1 selects read and set to 0 selects write. On a mismatch the block does not acknowledge and ignores the bus until the next START.
- R3: Bits are sampled on the rising bus clock. The pull-low enable is asserted throughout the ninth clock after each accepted byte and stays off during received data bits. It changes only after a falling bus clock or a START/STOP.
- R4: After an accepted write control byte, the next two bytes form the word address, high byte first.
- R5: Each received data byte produces a one-cycle wrStrobe carrying wrData and wrAddr. The address then advances only in its lower PAGE_W bits, wrapping inside the page.
- R6: A STOP after at least one data byte produces a one-cycle wrCommit. A repeated START in place of data keeps the loaded address, produces no commit, and lets a following read start from that address.
- R7: A read sends the byte at the address counter, MSB first, and the counter then increments. After the top address the counter wraps to 0.
- R8: A master acknowledge (data line low in the ninth clock) after a read byte requests the next byte. A master no-acknowledge releases the line, and the block stays silent until the next START.
- R9: While busyIn is high, a control byte is not acknowledged, for reads and for writes alike.
- R10: After reset the pull-low enable is off, no strobe is active and the address counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level |
| strapPins | input | 3 | Device select straps compared with control bits 3:1 |
| busyIn | input | 1 | Internal write cycle in progress |
| rdData | input | 8 | Array data at rdAddr |
| rdAddr | output | ADDR_W | Current address counter |
| sdaPullLow | output | 1 | Pull the data line low when high |
| wrStrobe | output | 1 | One-cycle pulse per received data byte |
| wrData | output | 8 | Received data byte |
| wrAddr | output | ADDR_W | Target address of wrData |
| wrCommit | output | 1 | One-cycle pulse when a STOP closes a write |

## Verification
The hardest cases to reach from the ports are the refusal while busy and the wrap of the counter at the top of the array. Both depend on state that is set up by earlier transactions. The bench holds busyIn high across complete read and write control bytes, then confirms that the refused read left the counter untouched. It reaches the top address through a dummy write to the last-but-one address followed by a repeated START. A full sweep of all 256 control bytes covers the decode, and a page write that runs past the end of its page covers the in-page wrap.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} busState_e;
  typedef enum logic [1:0] {K_CTRL, K_AHI, K_ALO, K_DATA} byteKind_e;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startEv;
    logic stopEv;
    logic sdaLvl;
  } busEv_t;

  typedef struct packed {
    logic shiftIn;
    logic clrCnt;
    logic loadHi;
    logic loadAddr;
    logic takeData;
    logic loadTx;
    logic shiftTx;
    logic ackDrive;
    logic txEn;
  } dpCmd_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync
  import ee_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  output busEv_t ev
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;
  logic sclS, sdaS;

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  always_comb begin
    ev.sclRise = sclS & ~sclPrev;
    ev.sclFall = ~sclS & sclPrev;
    ev.startEv = sclS & sclPrev & sdaPrev & ~sdaS;
    ev.stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;
    ev.sdaLvl  = sdaS;
  end
endmodule

// File: rtl/ee_ctrl.sv
module ee_ctrl
  import ee_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busEv_t     ev,
  input  logic [7:0] rxByte,
  input  logic [3:0] bitCnt,
  input  logic [2:0] strapPins,
  input  logic       busyIn,
  output dpCmd_t     cmd,
  output logic       wrCommit
);
  busState_e stateQ, stateN;
  byteKind_e kindQ, kindN;
  logic readQ, readN, wrPendQ, wrPendN, commitQ, commitN;
  logic ctrlMatch;

  assign ctrlMatch = (rxByte[7:4] == DEV_TYPE) && (rxByte[3:1] == strapPins) && !busyIn;
  assign wrCommit = commitQ;

  always_comb begin
    cmd = '0;
    cmd.ackDrive = (stateQ == ST_ACK);
    cmd.txEn = (stateQ == ST_TX);
    stateN = stateQ;
    kindN = kindQ;
    readN = readQ;
    wrPendN = wrPendQ;
    commitN = 1'b0;
    if (ev.stopEv) begin
      stateN = ST_IDLE;
      commitN = wrPendQ;
      wrPendN = 1'b0;
    end else if (ev.startEv) begin
      stateN = ST_RX;
      kindN = K_CTRL;
      cmd.clrCnt = 1'b1;
      wrPendN = 1'b0;
    end else begin
      unique case (stateQ)
        ST_RX: begin
          if (ev.sclRise) cmd.shiftIn = 1'b1;
          if (ev.sclFall && bitCnt == 4'd8) begin
            stateN = ST_ACK;
            unique case (kindQ)
              K_CTRL: begin
                if (ctrlMatch) readN = rxByte[0];
                else stateN = ST_IDLE;
              end
              K_AHI: cmd.loadHi = 1'b1;
              K_ALO: cmd.loadAddr = 1'b1;
              default: begin
                cmd.takeData = 1'b1;
                wrPendN = 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (ev.sclFall) begin
            cmd.clrCnt = 1'b1;
            if (kindQ == K_CTRL && readQ) begin
              cmd.loadTx = 1'b1;
              stateN = ST_TX;
            end else begin
              stateN = ST_RX;
              unique case (kindQ)
                K_CTRL: kindN = K_AHI;
                K_AHI: kindN = K_ALO;
                default: kindN = K_DATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (ev.sclRise) cmd.shiftIn = 1'b1;
          if (ev.sclFall) begin
            if (bitCnt == 4'd8) stateN = ST_MACK;
            else cmd.shiftTx = 1'b1;
          end
        end
        ST_MACK: begin
          if (ev.sclRise) cmd.shiftIn = 1'b1;
          if (ev.sclFall) begin
            if (!rxByte[0]) begin
              cmd.loadTx = 1'b1;
              cmd.clrCnt = 1'b1;
              stateN = ST_TX;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      kindQ <= K_CTRL;
      readQ <= 1'b0;
      wrPendQ <= 1'b0;
      commitQ <= 1'b0;
    end else begin
      stateQ <= stateN;
      kindQ <= kindN;
      readQ <= readN;
      wrPendQ <= wrPendN;
      commitQ <= commitN;
    end
  end

  // Entering the ack slot of a control byte requires idle write engine.
  assert_no_ack_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACK && kindQ == K_CTRL && $past(stateQ) != ST_ACK) |-> !$past(busyIn));

  assert_ctrl_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACK && kindQ == K_CTRL && $past(stateQ) != ST_ACK)
      |-> ($past(rxByte[7:4]) == 4'b1010 && $past(rxByte[3:1]) == $past(strapPins)));

  assert_stop_idles_R1: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopEv |=> stateQ == ST_IDLE);

  assert_commit_on_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |-> $past(ev.stopEv));
endmodule

// File: rtl/ee_datapath.sv
module ee_datapath
  import ee_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              sdaLvl,
  input  logic [7:0]        rdData,
  output logic [7:0]        rxByte,
  output logic [3:0]        bitCnt,
  output logic [ADDR_W-1:0] addrCnt,
  output logic              sdaPullLow,
  output logic              wrStrobe,
  output logic [7:0]        wrData,
  output logic [ADDR_W-1:0] wrAddr
);
  localparam int HI_W = ADDR_W - 8;

  logic [7:0] rxShift, txShift;
  logic [HI_W-1:0] addrHiQ;
  logic [PAGE_W-1:0] pageNext;

  assign rxByte = rxShift;
  assign pageNext = addrCnt[PAGE_W-1:0] + 1'b1;
  assign sdaPullLow = cmd.ackDrive | (cmd.txEn & ~txShift[7]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      bitCnt <= '0;
      addrHiQ <= '0;
      addrCnt <= '0;
      wrStrobe <= 1'b0;
      wrData <= '0;
      wrAddr <= '0;
    end else begin
      if (cmd.shiftIn) rxShift <= {rxShift[6:0], sdaLvl};
      if (cmd.clrCnt) bitCnt <= '0;
      else if (cmd.shiftIn) bitCnt <= bitCnt + 1'b1;
      if (cmd.loadHi) addrHiQ <= rxShift[HI_W-1:0];
      if (cmd.loadAddr) begin
        addrCnt <= {addrHiQ, rxShift};
      end else if (cmd.takeData) begin
        addrCnt <= {addrCnt[ADDR_W-1:PAGE_W], pageNext};
      end else if (cmd.loadTx) begin
        addrCnt <= addrCnt + 1'b1;
      end
      if (cmd.takeData) begin
        wrData <= rxShift;
        wrAddr <= addrCnt;
      end
      wrStrobe <= cmd.takeData;
      if (cmd.loadTx) txShift <= rdData;
      else if (cmd.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  assert_page_roll_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (addrCnt[ADDR_W-1:PAGE_W] == wrAddr[ADDR_W-1:PAGE_W]
                  && addrCnt[PAGE_W-1:0] == PAGE_W'(wrAddr[PAGE_W-1:0] + 1'b1)));

  assert_read_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.loadTx) |-> addrCnt == ADDR_W'($past(addrCnt) + 1'b1));
endmodule

// File: rtl/eeprom_bus_engine.sv
module eeprom_bus_engine
  import ee_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        strapPins,
  input  logic              busyIn,
  input  logic [7:0]        rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              sdaPullLow,
  output logic              wrStrobe,
  output logic [7:0]        wrData,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              wrCommit
);
  busEv_t ev;
  dpCmd_t cmd;
  logic [7:0] rxByte;
  logic [3:0] bitCnt;

  ee_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ev(ev)
  );

  ee_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .bitCnt(bitCnt),
    .strapPins(strapPins), .busyIn(busyIn), .cmd(cmd), .wrCommit(wrCommit)
  );

  ee_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaLvl(ev.sdaLvl), .rdData(rdData),
    .rxByte(rxByte), .bitCnt(bitCnt), .addrCnt(rdAddr), .sdaPullLow(sdaPullLow),
    .wrStrobe(wrStrobe), .wrData(wrData), .wrAddr(wrAddr)
  );

  // The line moves only behind a falling bus clock or a bus condition.
  assert_sda_after_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> $past(ev.sclFall | ev.startEv | ev.stopEv));
endmodule

// File: tb/test_eeprom_bus_engine.sv
module test_eeprom_bus_engine;
  localparam int ADDR_W = 16;
  localparam int Q = 5;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic busy = 1'b0;
  logic [7:0] rdData;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic sdaPullLow, wrStrobe, wrCommit;
  logic [7:0] wrData;
  wire sdaLine = mSda & ~sdaPullLow;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hC3;
  endfunction
  assign rdData = pat(rdAddr);

  eeprom_bus_engine i_eeprom_bus_engine (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .strapPins(strap),
    .busyIn(busy), .rdData(rdData), .rdAddr(rdAddr), .sdaPullLow(sdaPullLow),
    .wrStrobe(wrStrobe), .wrData(wrData), .wrAddr(wrAddr), .wrCommit(wrCommit)
  );

  int checks = 0, fails = 0;
  int logN = 0, commitN = 0;
  logic [15:0] logA [0:63];
  logic [7:0] logD [0:63];

  always @(negedge clk) begin
    if (wrStrobe && logN < 64) begin
      logA[logN] = wrAddr;
      logD[logN] = wrData;
      logN++;
    end
    if (wrCommit) commitN++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    mSda = 1'b1; w(Q); mScl = 1'b1; w(H); mSda = 1'b0; w(H); mScl = 1'b0; w(Q);
  endtask

  task automatic stopC();
    mSda = 1'b0; w(Q); mScl = 1'b1; w(H); mSda = 1'b1; w(H);
  endtask

  task automatic clockBit(input bit b, output bit s, output bit drove);
    mSda = b; w(Q); mScl = 1'b1; w(H / 2);
    s = sdaLine; drove = sdaPullLow;
    w(H / 2); mScl = 1'b0; w(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked, output bit bad);
    bit s, d;
    bad = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      clockBit(b[i], s, d);
      if (d) bad = 1'b1;
    end
    clockBit(1'b1, s, d);
    acked = !s;
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] v);
    bit s, d;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, s, d);
      v = {v[6:0], s};
    end
    clockBit(!giveAck, s, d);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R1 watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    bit ack, bad, any, s, d;
    logic [7:0] v;
    int base, c0;
    w(10);
    check(sdaPullLow == 1'b0, "R10 pull", sdaPullLow, 0);
    check(wrStrobe == 1'b0 && wrCommit == 1'b0, "R10 strobes", wrStrobe, 0);
    check(rdAddr == '0, "R10 counter", rdAddr, 0);
    rstN = 1'b1;
    w(10);

    // R2 sweep of every control byte with straps 101
    for (int cb = 0; cb < 256; cb++) begin
      bit expAck;
      expAck = (cb[7:4] == 4'hA) && (cb[3:1] == strap);
      startC();
      sendByte(8'(cb), ack, bad);
      check(ack == expAck, "R2 decode", ack, expAck);
      if (ack) check(!bad, "R3 no drive in data bits", bad, 0);
      if (ack && cb[0]) readByte(1'b0, v);
      stopC();
    end

    // R2 mismatch ignores following bytes
    startC();
    sendByte(8'hA0, ack, bad);
    sendByte(8'hAA, ack, bad);
    check(!ack, "R2 ignored after mismatch", ack, 0);
    stopC();

    // R1 bytes without START, and STOP mid address
    sendByte(8'hAA, ack, bad);
    check(!ack, "R1 no START", ack, 0);
    c0 = commitN;
    startC();
    sendByte(8'hAA, ack, bad);
    sendByte(8'h12, ack, bad);
    stopC();
    sendByte(8'h34, ack, bad);
    check(!ack, "R1 after STOP", ack, 0);
    check(commitN == c0, "R6 no commit without data", commitN, c0);

    // R4 R5 R6 page write crossing the page end
    base = logN;
    startC();
    sendByte(8'hAA, ack, bad);
    sendByte(8'h12, ack, bad);
    check(ack, "R4 high address ack", ack, 1);
    sendByte(8'h78, ack, bad);
    check(ack, "R4 low address ack", ack, 1);
    for (int k = 0; k < 10; k++) begin
      sendByte(8'(k * 7 + 3), ack, bad);
      check(ack && !bad, "R3 data ack", ack, 1);
    end
    stopC();
    w(4);
    check(logN == base + 10, "R5 strobe count", logN - base, 10);
    for (int k = 0; k < 10; k++) begin
      logic [15:0] ea;
      ea = {8'h12, 1'b0, 7'((8'h78 + k) & 8'h7F)};
      check(logA[base + k] == ea, "R5 address", logA[base + k], ea);
      check(logD[base + k] == 8'(k * 7 + 3), "R5 data", logD[base + k], k * 7 + 3);
    end
    check(commitN == c0 + 1, "R6 commit", commitN, c0 + 1);

    // R7 R8 sequential then current-address read
    startC();
    sendByte(8'hAB, ack, bad);
    for (int k = 0; k < 3; k++) begin
      readByte(k < 2, v);
      check(v == pat(16'h1202 + 16'(k)), "R8 sequential", v, pat(16'h1202 + 16'(k)));
    end
    stopC();
    startC();
    sendByte(8'hAB, ack, bad);
    readByte(1'b0, v);
    check(v == pat(16'h1205), "R7 current read", v, pat(16'h1205));
    stopC();

    // R6 R7 random read through the top of the array
    base = logN;
    c0 = commitN;
    startC();
    sendByte(8'hAA, ack, bad);
    sendByte(8'hFF, ack, bad);
    sendByte(8'hFE, ack, bad);
    startC();
    sendByte(8'hAB, ack, bad);
    check(ack, "R6 repeated START read ack", ack, 1);
    for (int k = 0; k < 3; k++) begin
      logic [15:0] ea;
      ea = 16'hFFFE + 16'(k);
      readByte(k < 2, v);
      check(v == pat(ea), "R7 wrap", v, pat(ea));
    end
    stopC();
    w(4);
    check(logN == base && commitN == c0, "R6 dummy write silent", logN - base, 0);

    // R8 NACK releases the line
    startC();
    sendByte(8'hAB, ack, bad);
    readByte(1'b0, v);
    check(v == pat(16'h0001), "R8 read before NACK", v, pat(16'h0001));
    any = 1'b0;
    for (int k = 0; k < 9; k++) begin
      clockBit(1'b1, s, d);
      if (d) any = 1'b1;
    end
    check(!any, "R8 silent after NACK", any, 0);
    stopC();

    // R9 busy refuses both directions
    busy = 1'b1;
    startC();
    sendByte(8'hAA, ack, bad);
    check(!ack, "R9 write refused", ack, 0);
    stopC();
    startC();
    sendByte(8'hAB, ack, bad);
    check(!ack, "R9 read refused", ack, 0);
    stopC();
    busy = 1'b0;
    startC();
    sendByte(8'hAB, ack, bad);
    check(ack, "R9 accepted when idle", ack, 1);
    readByte(1'b0, v);
    check(v == pat(16'h0002), "R9 counter untouched", v, pat(16'h0002));
    stopC();

    // R2 other strap value
    strap = 3'b010;
    startC();
    sendByte(8'hA4, ack, bad);
    check(ack, "R2 strap 010 match", ack, 1);
    stopC();
    startC();
    sendByte(8'hAA, ack, bad);
    check(!ack, "R2 strap 010 old address", ack, 0);
    stopC();

    summary();
    $finish;
  end
endmodule